// File: doc/BRIEF.md
# Two-Bank Matrix Keypad Scanner

This block scans two separate 4x4 switch matrices, 32 keys in all. Each matrix has four row lines that are pulled low by an open-drain driver and four column lines with external pull-ups. The scanner walks one row index at a time, with the same row index active in both banks. The interval between row advances comes from a clock-derived tick of either one or two milliseconds. On every tick, the column lines are read for the row that has been held low since the previous tick. The row then advances. Because of this, each column line has a whole interval to settle, so long cables with heavy filtering still read correctly.

Each key is debounced on its own. A new level is accepted only when two consecutive samples of that key, taken one full scan apart, agree with each other and differ from the reported level. When a key is accepted, the scanner updates a 32-bit pressed-key vector and raises a one-cycle press or release strobe. A full scan takes four intervals, which is 4 ms or 8 ms. Either way, a consumer that polls every 10 ms sees all 32 keys refreshed.

Top module: `dual_bank_key_scanner`

## Requirements
- R1: Key number k = bank*16 + row*4 + col. Row line (bank b, row r) is `row_pull[b*4+r]`, where 1 means pulled low and 0 means released. Column line (bank b, col c) is `col_n[b*4+c]`, where 0 means the switch at the active row is closed.
- R2: In each bank exactly one row is pulled at any time, with the same row index in both banks. The index runs 0,1,2,3,0,… and is 0 after reset.
- R3: The row index advances once every CYC_PER_MS clock cycles when `rate_sel` is 0, and once every 2*CYC_PER_MS cycles when it is 1. It stays unchanged in between.
- R4: On the advancing clock edge, the columns are sampled for the row pulled during the interval just ending. All 32 keys are therefore sampled once every four intervals, which is within 10 ms at either rate.
- R5: A `key_down` bit changes only when two consecutive samples of that key agree and differ from the bit. A level seen in a single sample is ignored.
- R6: When a key is accepted, `key_press` (for a new pressed level) or `key_release` (for a new released level) is high for exactly one clock cycle, in the same cycle that `key_down` takes the new value. Both strobes are never high together for one key.
- R7: After reset, `key_down` is all zero and no strobe appears. A key held closed through reset is reported only after at least one full scan, which is no earlier than 4*CYC_PER_MS cycles.
- R8: The banks are independent. Keys at the same row and column in both banks are accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 1 | Row interval select: 0 = one ms, 1 = two ms |
| col_n | input | 8 | Column lines of both banks, active low |
| row_pull | output | 8 | Row pull-low enables; a row whose bit is 0 is released to high impedance |
| key_down | output | 32 | Debounced pressed state per key |
| key_press | output | 32 | One-cycle strobe when a key is accepted as pressed |
| key_release | output | 32 | One-cycle strobe when a key is accepted as released |

## Verification
The bench tests with several input patterns, and each one separates a different kind of fault:
- A key held closed through reset shows whether the scanner waits for a second sample before reporting.
- A closure that spans exactly one sample of its row separates a real two-sample filter from a pass-through.
- Matching keys in both banks, and dense mixed 32-bit patterns, expose swapped index, row or bank wiring.
- The row-interval measurement at both rate settings separates the two tick periods.

A behavioural model, run every clock, catches any cycle shift of the row drive, the pressed vector or the strobes.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } scan_rate_e;

  localparam int DEF_BANKS = 2;
  localparam int DEF_ROWS  = 4;
  localparam int DEF_COLS  = 4;
endpackage

// File: rtl/kscan_tick.sv
module kscan_tick #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  output logic tick_o
);
  import kscan_pkg::*;
  localparam int CW = $clog2(2 * CYC_PER_MS);

  logic [CW-1:0] cnt_q, cnt_d, last_c;

  always_comb begin
    last_c = (scan_rate_e'(rate_sel) == RATE_SLOW) ? CW'(2 * CYC_PER_MS - 1)
                                                   : CW'(CYC_PER_MS - 1);
    tick_o = (cnt_q >= last_c);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: ticks never come back to back
  assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R3: the counter stays within the long period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(2 * CYC_PER_MS - 1));
endmodule

// File: rtl/kscan_rowseq.sv
module kscan_rowseq #(
  parameter int ROWS  = 4,
  parameter int BANKS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  output logic [$clog2(ROWS)-1:0]  row_idx_o,
  output logic [BANKS*ROWS-1:0]    row_pull_o
);
  localparam int RW = $clog2(ROWS);

  logic [RW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (tick_i) idx_d = (idx_q == RW'(ROWS - 1)) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign row_idx_o = idx_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_pull_o[b*ROWS + r] = (idx_q == RW'(r));
    end
    // R2: exactly one row pulled per bank
    assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_pull_o[b*ROWS +: ROWS]) == 1);
  end

  // R3: rows hold between ticks
  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(row_pull_o));
  // R2: every tick moves to another row
  assert_row_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (row_pull_o != $past(row_pull_o)));
endmodule

// File: rtl/kscan_debounce.sv
module kscan_debounce #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic [$clog2(ROWS)-1:0] row_idx_i,
  input  logic [COLS-1:0]         col_n_i,
  output logic [ROWS*COLS-1:0]    state_o,
  output logic [ROWS*COLS-1:0]    press_o,
  output logic [ROWS*COLS-1:0]    release_o
);
  localparam int RW = $clog2(ROWS);
  localparam int NK = ROWS * COLS;

  logic [NK-1:0] samp_q, samp_d, state_q, state_d;
  logic [NK-1:0] press_q, press_d, rel_q, rel_d;

  always_comb begin
    samp_d  = samp_q;
    state_d = state_q;
    press_d = '0;
    rel_d   = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (tick_i && (row_idx_i == RW'(r))) begin
          samp_d[r*COLS + c] = ~col_n_i[c];
          if ((~col_n_i[c] == samp_q[r*COLS + c]) &&
              (~col_n_i[c] != state_q[r*COLS + c])) begin
            state_d[r*COLS + c] = ~col_n_i[c];
            press_d[r*COLS + c] = ~col_n_i[c];
            rel_d[r*COLS + c]   = col_n_i[c];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      state_q <= '0;
      press_q <= '0;
      rel_q   <= '0;
    end else begin
      samp_q  <= samp_d;
      state_q <= state_d;
      press_q <= press_d;
      rel_q   <= rel_d;
    end
  end

  assign state_o   = state_q;
  assign press_o   = press_q;
  assign release_o = rel_q;

  // R6: a key never strobes press and release together
  assert_no_dual_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (press_q & rel_q) == '0);
  // R6: strobes agree with the new state
  assert_evt_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((press_q & ~state_q) | (rel_q & state_q)) == '0);
  // R6: every state change carries a strobe
  assert_change_strobed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> ((state_q ^ $past(state_q)) == (press_q | rel_q)));
  // R5: state only moves on a sampling tick
  assert_change_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> $past(tick_i));
endmodule

// File: rtl/dual_bank_key_scanner.sv
module dual_bank_key_scanner #(
  parameter int CYC_PER_MS = 50000,
  parameter int BANKS      = kscan_pkg::DEF_BANKS,
  parameter int ROWS       = kscan_pkg::DEF_ROWS,
  parameter int COLS       = kscan_pkg::DEF_COLS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rate_sel,
  input  logic [BANKS*COLS-1:0]       col_n,
  output logic [BANKS*ROWS-1:0]       row_pull,
  output logic [BANKS*ROWS*COLS-1:0]  key_down,
  output logic [BANKS*ROWS*COLS-1:0]  key_press,
  output logic [BANKS*ROWS*COLS-1:0]  key_release
);
  localparam int RW  = $clog2(ROWS);
  localparam int KPB = ROWS * COLS;

  logic          rst_s1_q, rst_s2_q;
  logic          tick;
  logic [RW-1:0] row_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  kscan_tick #(.CYC_PER_MS(CYC_PER_MS)) tick_i (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .rate_sel(rate_sel),
    .tick_o  (tick)
  );

  kscan_rowseq #(.ROWS(ROWS), .BANKS(BANKS)) rows_i (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .tick_i    (tick),
    .row_idx_o (row_idx),
    .row_pull_o(row_pull)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    kscan_debounce #(.ROWS(ROWS), .COLS(COLS)) deb_i (
      .clk      (clk),
      .rst_n    (rst_s2_q),
      .tick_i   (tick),
      .row_idx_i(row_idx),
      .col_n_i  (col_n[b*COLS +: COLS]),
      .state_o  (key_down[b*KPB +: KPB]),
      .press_o  (key_press[b*KPB +: KPB]),
      .release_o(key_release[b*KPB +: KPB])
    );
  end

  // R7: nothing reported while held in reset
  assert_quiet_in_reset_R7: assert property (@(posedge clk)
    !rst_s2_q |-> (key_down == '0 && key_press == '0 && key_release == '0));
endmodule

// File: tb/dual_bank_key_scanner_tb.sv
module dual_bank_key_scanner_tb_top;
  localparam int CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_sel = 1'b0;
  logic [31:0] keys = '0;
  logic [7:0]  col_n;
  logic [7:0]  row_pull;
  logic [31:0] key_down, key_press, key_release;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 1'b0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dual_bank_key_scanner #(.CYC_PER_MS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .col_n(col_n),
    .row_pull(row_pull), .key_down(key_down), .key_press(key_press),
    .key_release(key_release)
  );

  // physical matrix: a closed switch ties its column to a pulled row
  always_comb begin
    col_n = '1;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          if (row_pull[b*4+r] && keys[b*16+r*4+c]) col_n[b*4+c] = 1'b0;
  end

  // behavioural reference
  int          m_sync = 0, m_cnt = 0, m_row = 0;
  logic [31:0] m_samp = '0, m_down = '0, m_press = '0, m_rel = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_cnt = 0; m_row = 0;
      m_samp = '0; m_down = '0; m_press = '0; m_rel = '0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int lim;
      lim = rate_sel ? 2*CYC - 1 : CYC - 1;
      m_press = '0; m_rel = '0;
      if (m_cnt >= lim) begin
        m_cnt = 0;
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < 4; c++) begin
            int k;
            k = b*16 + m_row*4 + c;
            if (keys[k] == m_samp[k] && keys[k] != m_down[k]) begin
              m_down[k] = keys[k];
              if (keys[k]) m_press[k] = 1'b1; else m_rel[k] = 1'b1;
            end
            m_samp[k] = keys[k];
          end
        m_row = (m_row + 1) % 4;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    logic [7:0] er;
    er = '0;
    er[m_row] = 1'b1; er[4 + m_row] = 1'b1;
    check(row_pull == er, "R2 row drive", {24'b0, row_pull}, {24'b0, er});
    check(key_down == m_down, "R4/R5 key_down", key_down, m_down);
    check(key_press == m_press, "R6 key_press", key_press, m_press);
    check(key_release == m_rel, "R6 key_release", key_release, m_rel);
  end

  function automatic int cur_row();
    for (int r = 0; r < 4; r++) if (row_pull[r]) return r;
    return -1;
  endfunction

  task automatic wait_row(input int r);
    do @(negedge clk); while (cur_row() != r);
  endtask

  task automatic wait_scans(input int n);
    repeat (n * 4 * CYC * (rate_sel ? 2 : 1)) @(negedge clk);
  endtask

  initial begin
    int cnt, r0;
    keys[5] = 1'b1;                      // held closed through reset
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check(key_down == '0, "R7 reset state", key_down, '0);
    check(key_press == '0 && key_release == '0, "R7 no strobes", key_press, '0);

    cnt = 1;
    while (!key_press[5] && cnt < 2000) begin @(negedge clk); cnt++; end
    check(cnt >= 4*CYC && key_press[5], "R7 first event after full scan", cnt, 4*CYC);

    // R3: interval length at both rates
    r0 = cur_row();
    do @(negedge clk); while (cur_row() == r0);
    r0 = cur_row(); cnt = 0;
    do begin @(negedge clk); cnt++; end while (cur_row() == r0);
    check(cnt == CYC, "R3 fast interval", cnt, CYC);
    rate_sel = 1'b1;
    r0 = cur_row();
    do @(negedge clk); while (cur_row() == r0);
    r0 = cur_row(); cnt = 0;
    do begin @(negedge clk); cnt++; end while (cur_row() == r0);
    check(cnt == 2*CYC, "R3 slow interval", cnt, 2*CYC);

    keys[5] = 1'b0;
    wait_scans(3);
    check(key_down[5] == 1'b0, "R6 release accepted", key_down, '0);

    // R5: closure seen by a single sample only
    wait_row(2);
    keys[10] = 1'b1;
    wait_row(3);
    keys[10] = 1'b0;
    wait_scans(3);
    check(key_down[10] == 1'b0, "R5 glitch ignored", key_down, '0);

    // R8: same position in both banks
    keys[3] = 1'b1; keys[19] = 1'b1;
    cnt = 0;
    while (!key_press[3] && cnt < 4000) begin @(negedge clk); cnt++; end
    check(key_press[19] == 1'b1, "R8 banks together", key_press, 32'h0008_0008);
    check(key_down == 32'h0008_0008, "R1 index mapping", key_down, 32'h0008_0008);
    keys[3] = 1'b0; keys[19] = 1'b0;
    cnt = 0;
    while (!key_release[3] && cnt < 4000) begin @(negedge clk); cnt++; end
    check(key_release == 32'h0008_0008, "R6 release strobe", key_release, 32'h0008_0008);
    @(negedge clk);
    check(key_release == '0, "R6 strobe one cycle", key_release, '0);

    // R4: dense patterns, refreshed within a bounded number of scans
    keys = 32'hA5C3_0F18;
    wait_scans(3);
    check(key_down == 32'hA5C3_0F18, "R4 pattern A", key_down, 32'hA5C3_0F18);
    rate_sel = 1'b0;
    keys = 32'h5A3C_F0E7;
    wait_scans(3);
    check(key_down == 32'h5A3C_F0E7, "R4 pattern B", key_down, 32'h5A3C_F0E7);
    keys = 32'h8001_0001;
    wait_scans(3);
    check(key_down == 32'h8001_0001, "R1 corner keys", key_down, 32'h8001_0001);
    keys = '0;
    wait_scans(3);
    check(key_down == '0, "R6 all released", key_down, '0);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule